// File: doc/BRIEF.md
# Dual-Image Boot Jump Controller

This controller lives inside each configuration image of a two-image FPGA system, where a golden image sits at flash address 0x00000000 and a production image at 0x00010000. On request it drives a 32-bit internal configuration port to read the boot-status register. The register is read-only and holds two records: one for the current configuration and one for the previous one. The controller decodes both records. Running as golden, it moves on to production only when neither record shows an internal reprogram or an error. A deliberate return to golden is therefore never undone. Running as production, a plain request only reads the status and returns.

A separate forced-return request takes the system back to golden in one of two ways. It either points the warm-boot address at golden and reprograms, or it loads the configuration watchdog with a very short monitor-mode count before reprogramming toward production. In the second case the load times out and falls back to golden. Golden then writes the normal timer value back whenever it evaluates a plain request.

Every port word takes one cycle with select and write asserted. A status read ends in a read cycle that waits for the port's valid strobe, and a counter bounds that wait.

Top module: `mbj_jump_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `err` and `cfg_cs` are all 0.
- R2: Each session starts with the words 0xFFFFFFFF, 0xAA995566 and 0x20000000. It ends with 0x20000000, a command-register write header and the desync code 0x0000000D. Each word is sent in one cycle with `cfg_cs` and `cfg_wr` high.
- R3: A status read sends the read header 0x2802C001, then `RD_WAIT` no-op words (0x20000000), then holds `cfg_cs`=1 with `cfg_wr`=0 until `cfg_rvalid` is seen, and captures `cfg_dout`.
- R4: No header sent on the port ever writes register 0x16, the boot-status register. Write headers have bits [31:27]=00110 and the register number in bits [17:13].
- R5: The status word holds the current record in [15:0] and the previous record in [31:16]. Each record has: bit0 valid, bit1 fallback, bit2 internal reprogram, bit3 ID mismatch, bit4 CRC error, bit5 watchdog timeout. As golden (`is_golden`=1), if neither record has bits 1 to 5 set, the controller sends, in order: timer header 0x30022001, the normal timer word, warm-address header 0x30020001, the word 0x00010000, command header 0x30008001, and reprogram code 0x0000000F.
- R6: As golden, if either record has the internal-reprogram bit set, the controller sends the timer restore and then the closing words, and no warm-address write and no reprogram.
- R7: As golden, if either record has a fallback, ID-mismatch, CRC or watchdog bit set, the controller does not jump.
- R8: As production (`is_golden`=0), a plain start reads the status and closes the session with no register write.
- R9: `force_req` with `force_wdt`=0 skips the status read and sends the warm-address header, the word 0x00000000, the command header and the reprogram code.
- R10: `force_req` with `force_wdt`=1 sends the timer header, the word 0x40000000 | `TMR_SHORT` (bit 30 selects monitor mode), the warm-address header, the word 0x00010000, the command header and the reprogram code.
- R11: `busy` is high from the cycle after a request is accepted until the last word. `done` is a one-cycle pulse in the first idle cycle, and it never coincides with `busy`.
- R12: `start` and `force_req` pulses that arrive while `busy` is high start nothing, either during that session or after it. If both arrive together while idle, the forced request wins.
- R13: If `cfg_rvalid` does not arrive within `RD_TMO` read cycles, `err` rises, no jump is made, and the closing words follow. `err` stays high until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: read status and decide |
| force_req | input | 1 | Pulse: forced return to golden |
| force_wdt | input | 1 | Forced mode: 1 = short watchdog, 0 = direct address |
| is_golden | input | 1 | High when this image is the golden one |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| err | output | 1 | Sticky status-read timeout flag |
| cfg_cs | output | 1 | Configuration port select |
| cfg_wr | output | 1 | 1 = write word, 0 = read cycle |
| cfg_din | output | 32 | Word sent to the configuration port |
| cfg_dout | input | 32 | Word returned by the configuration port |
| cfg_rvalid | input | 1 | `cfg_dout` holds valid read data |

## Verification
The bench builds the controller with `RD_WAIT`=2, so each read spends two no-op cycles before its read cycles. It uses `RD_TMO`=8, so a silenced port model reaches the timeout path in a few cycles instead of the default. `TMR_SHORT` and `TMR_NORMAL` are set to distinct non-zero values (0x10 and 0x3000), so the expected word lists tell the forced-watchdog write apart from the golden restore write. The port model answers reads with status words that set one flag at a time in either record, which exercises each stay condition separately.

// File: rtl/mbj_pkg.sv
package mbj_pkg;

    localparam int unsigned WW = 32;

    localparam logic [WW-1:0] W_DUMMY  = 32'hFFFF_FFFF;
    localparam logic [WW-1:0] W_SYNC   = 32'hAA99_5566;
    localparam logic [WW-1:0] W_NOOP   = 32'h2000_0000;
    localparam logic [WW-1:0] C_REPROG = 32'h0000_000F;
    localparam logic [WW-1:0] C_DESYNC = 32'h0000_000D;
    localparam logic [WW-1:0] A_GOLD   = 32'h0000_0000;
    localparam logic [WW-1:0] A_PROD   = 32'h0001_0000;

    localparam logic [1:0] OP_RD = 2'b01;
    localparam logic [1:0] OP_WR = 2'b10;

    localparam logic [4:0] RG_CMD  = 5'h04;
    localparam logic [4:0] RG_WARM = 5'h10;
    localparam logic [4:0] RG_TMR  = 5'h11;
    localparam logic [4:0] RG_BOOT = 5'h16;

    typedef enum logic [4:0] {
        S_IDLE, S_PRE0, S_PRE1, S_PRE2,
        S_RDHDR, S_RDWAIT, S_RDCAP, S_DECIDE,
        S_TMRHDR, S_TMRDAT, S_WBHDR, S_WBDAT,
        S_CMDHDR, S_CMDDAT, S_TNOOP, S_DSHDR, S_DSDAT
    } seq_st_t;

    typedef struct packed {
        logic valid;
        logic fallback;
        logic reprog;
        logic failed;
    } boot_rec_t;

    typedef struct packed {
        logic          cs;
        logic          wr;
        logic [WW-1:0] din;
    } port_word_t;

    function automatic logic [WW-1:0] t1_hdr(input logic [1:0] op, input logic [4:0] ra);
        return {3'b001, op, 9'd0, ra, 2'b00, 11'd1};
    endfunction

    function automatic logic [WW-1:0] tmr_word(input logic mon, input logic [29:0] val);
        return {1'b0, mon, val};
    endfunction

endpackage

// File: rtl/mbj_rec_decode.sv
module mbj_rec_decode
    import mbj_pkg::*;
(
    input  logic [15:0] raw,
    output boot_rec_t   rec
);
    always_comb begin
        rec.valid    = raw[0];
        rec.fallback = raw[1];
        rec.reprog   = raw[2];
        rec.failed   = raw[1] | raw[3] | raw[4] | raw[5];
    end
endmodule

// File: rtl/mbj_step_timer.sv
module mbj_step_timer #(
    parameter int unsigned RD_WAIT = 2,
    parameter int unsigned RD_TMO  = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic wait_last,
    output logic tmo_last
);
    localparam int unsigned MAXC = (RD_WAIT > RD_TMO) ? RD_WAIT : RD_TMO;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != CW'(MAXC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wait_last = (cnt == CW'(RD_WAIT - 1));
    assign tmo_last  = (cnt == CW'(RD_TMO - 1));
endmodule

// File: rtl/mbj_word_gen.sv
module mbj_word_gen
    import mbj_pkg::*;
#(
    parameter logic [29:0] TMR_SHORT  = 30'h10,
    parameter logic [29:0] TMR_NORMAL = 30'h0
) (
    input  seq_st_t    st,
    input  logic       frc,
    input  logic       wdt,
    output port_word_t pw
);
    always_comb begin
        pw = '{cs: 1'b1, wr: 1'b1, din: W_NOOP};
        unique case (st)
            S_IDLE, S_DECIDE: pw = '{cs: 1'b0, wr: 1'b0, din: '0};
            S_PRE0:   pw.din = W_DUMMY;
            S_PRE1:   pw.din = W_SYNC;
            S_PRE2, S_RDWAIT, S_TNOOP: pw.din = W_NOOP;
            S_RDHDR:  pw.din = t1_hdr(OP_RD, RG_BOOT);
            S_RDCAP:  pw = '{cs: 1'b1, wr: 1'b0, din: '0};
            S_TMRHDR: pw.din = t1_hdr(OP_WR, RG_TMR);
            S_TMRDAT: pw.din = frc ? tmr_word(1'b1, TMR_SHORT) : tmr_word(1'b0, TMR_NORMAL);
            S_WBHDR:  pw.din = t1_hdr(OP_WR, RG_WARM);
            S_WBDAT:  pw.din = (frc && !wdt) ? A_GOLD : A_PROD;
            S_CMDHDR, S_DSHDR: pw.din = t1_hdr(OP_WR, RG_CMD);
            S_CMDDAT: pw.din = C_REPROG;
            S_DSDAT:  pw.din = C_DESYNC;
            default:  pw = '{cs: 1'b0, wr: 1'b0, din: '0};
        endcase
    end
endmodule

// File: rtl/mbj_jump_ctrl.sv
module mbj_jump_ctrl
    import mbj_pkg::*;
#(
    parameter int unsigned RD_WAIT    = 2,
    parameter int unsigned RD_TMO     = 1024,
    parameter logic [29:0] TMR_SHORT  = 30'h10,
    parameter logic [29:0] TMR_NORMAL = 30'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        force_req,
    input  logic        force_wdt,
    input  logic        is_golden,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        cfg_cs,
    output logic        cfg_wr,
    output logic [31:0] cfg_din,
    input  logic [31:0] cfg_dout,
    input  logic        cfg_rvalid
);
    localparam int unsigned NREC = 2;

    seq_st_t    st_q, st_d;
    logic       frc_q, wdt_q, img_q, go_q;
    logic [WW-1:0] stat_q;
    boot_rec_t  recs [NREC];
    logic       wait_last, tmo_last;
    logic       any_reprog, any_fail;
    port_word_t pw;

    for (genvar g = 0; g < NREC; g++) begin : g_rec
        mbj_rec_decode u_dec (
            .raw (stat_q[16*g +: 16]),
            .rec (recs[g])
        );
    end

    always_comb begin
        any_reprog = 1'b0;
        any_fail   = 1'b0;
        for (int i = 0; i < NREC; i++) begin
            any_reprog = any_reprog | recs[i].reprog;
            any_fail   = any_fail | recs[i].failed;
        end
    end

    mbj_step_timer #(.RD_WAIT(RD_WAIT), .RD_TMO(RD_TMO)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr       (st_d != st_q),
        .wait_last (wait_last),
        .tmo_last  (tmo_last)
    );

    mbj_word_gen #(.TMR_SHORT(TMR_SHORT), .TMR_NORMAL(TMR_NORMAL)) u_wg (
        .st  (st_q),
        .frc (frc_q),
        .wdt (wdt_q),
        .pw  (pw)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (force_req || start) st_d = S_PRE0;
            S_PRE0:   st_d = S_PRE1;
            S_PRE1:   st_d = S_PRE2;
            S_PRE2:   st_d = !frc_q ? S_RDHDR : (wdt_q ? S_TMRHDR : S_WBHDR);
            S_RDHDR:  st_d = S_RDWAIT;
            S_RDWAIT: if (wait_last) st_d = S_RDCAP;
            S_RDCAP: begin
                if (cfg_rvalid)    st_d = S_DECIDE;
                else if (tmo_last) st_d = S_TNOOP;
            end
            S_DECIDE: st_d = img_q ? S_TMRHDR : S_TNOOP;
            S_TMRHDR: st_d = S_TMRDAT;
            S_TMRDAT: st_d = (frc_q || go_q) ? S_WBHDR : S_TNOOP;
            S_WBHDR:  st_d = S_WBDAT;
            S_WBDAT:  st_d = S_CMDHDR;
            S_CMDHDR: st_d = S_CMDDAT;
            S_CMDDAT: st_d = S_TNOOP;
            S_TNOOP:  st_d = S_DSHDR;
            S_DSHDR:  st_d = S_DSDAT;
            S_DSDAT:  st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            frc_q  <= 1'b0;
            wdt_q  <= 1'b0;
            img_q  <= 1'b0;
            go_q   <= 1'b0;
            stat_q <= '0;
            err    <= 1'b0;
            done   <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= (st_q == S_DSDAT);
            if (st_q == S_IDLE && (force_req || start)) begin
                frc_q <= force_req;
                wdt_q <= force_req & force_wdt;
                img_q <= is_golden;
                go_q  <= 1'b0;
                err   <= 1'b0;
            end
            if (st_q == S_RDCAP) begin
                if (cfg_rvalid)    stat_q <= cfg_dout;
                else if (tmo_last) err    <= 1'b1;
            end
            if (st_q == S_DECIDE) begin
                go_q <= img_q & ~any_reprog & ~any_fail;
            end
        end
    end

    assign busy    = (st_q != S_IDLE);
    assign cfg_cs  = pw.cs;
    assign cfg_wr  = pw.wr;
    assign cfg_din = pw.din;
endmodule

// File: rtl/mbj_jump_ctrl_chk.sv
module mbj_jump_ctrl_chk
    import mbj_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        force_req,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        cfg_cs,
    input logic        cfg_wr,
    input logic [31:0] cfg_din
);
    // R2
    sync_after_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs && cfg_wr && cfg_din == W_SYNC) |-> $past(cfg_din) == W_DUMMY);

    // R3
    read_hdr_then_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs && cfg_wr && cfg_din == t1_hdr(OP_RD, RG_BOOT))
        |=> (cfg_cs && cfg_wr && cfg_din == W_NOOP));

    // R4
    no_status_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs && cfg_wr && cfg_din[31:27] == 5'b00110) |-> cfg_din[17:13] != RG_BOOT);

    // R5
    reprog_after_cmd_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cs && cfg_wr && cfg_din == C_REPROG) |-> $past(cfg_din) == t1_hdr(OP_WR, RG_CMD));

    // R11
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start || force_req));

    // R13
    err_clear_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(start || force_req));
endmodule

bind mbj_jump_ctrl mbj_jump_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .force_req (force_req),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cfg_cs    (cfg_cs),
    .cfg_wr    (cfg_wr),
    .cfg_din   (cfg_din)
);

// File: tb/mbj_jump_ctrl_tb_top.sv
module mbj_jump_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, force_req = 1'b0, force_wdt = 1'b0, is_golden = 1'b0;
    logic        busy, done, err, cfg_cs, cfg_wr;
    logic [31:0] cfg_din;
    logic [31:0] cfg_dout = '0;
    logic        cfg_rvalid = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] wlog [64];
    logic [31:0] exq  [64];
    int wcnt = 0, ecnt = 0;
    logic [31:0] model_stat = '0;
    logic        mute = 1'b0;

    always #4 clk = ~clk;

    mbj_jump_ctrl #(.RD_WAIT(2), .RD_TMO(8), .TMR_SHORT(30'h10), .TMR_NORMAL(30'h3000)) dut_i (
        .clk(clk), .rst(rst), .start(start), .force_req(force_req), .force_wdt(force_wdt),
        .is_golden(is_golden), .busy(busy), .done(done), .err(err),
        .cfg_cs(cfg_cs), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .cfg_rvalid(cfg_rvalid)
    );

    // configuration engine model: logs written words, answers read cycles
    always @(posedge clk) begin
        if (cfg_cs && cfg_wr && wcnt < 64) begin
            wlog[wcnt] = cfg_din;
            wcnt = wcnt + 1;
        end
        cfg_rvalid <= cfg_cs && !cfg_wr && !mute;
        cfg_dout   <= model_stat;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        exq[ecnt] = w;
        ecnt++;
    endtask

    task automatic push_pre();
        push(32'hFFFFFFFF); push(32'hAA995566); push(32'h20000000);
    endtask
    task automatic push_read();
        push(32'h2802C001); push(32'h20000000); push(32'h20000000);
    endtask
    task automatic push_tail();
        push(32'h20000000); push(32'h30008001); push(32'h0000000D);
    endtask
    task automatic push_jump(input logic [31:0] addr);
        push(32'h30020001); push(addr); push(32'h30008001); push(32'h0000000F);
    endtask

    task automatic cmp_log(input string req);
        chk({req, " word count"}, wcnt, ecnt);
        for (int i = 0; i < ecnt && i < wcnt; i++) chk(req, wlog[i], exq[i]);
    endtask

    // kind: 0 = start, 1 = forced direct, 2 = forced watchdog
    task automatic run_req(input int kind, input logic img, input logic [31:0] stat,
                           input logic poke, input logic exp_err, input string req);
        int guard;
        @(negedge clk);
        wcnt = 0;
        is_golden  = img;
        model_stat = stat;
        start      = (kind == 0);
        force_req  = (kind != 0);
        force_wdt  = (kind == 2);
        @(negedge clk);
        start = 1'b0; force_req = 1'b0; force_wdt = 1'b0;
        chk("R11 busy after accept", busy, 1'b1);
        if (poke) begin
            @(negedge clk); start = 1'b1; force_req = 1'b1;
            @(negedge clk); start = 1'b0; force_req = 1'b0;
        end
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk("R11 done seen", done, 1'b1);
        chk("R11 busy low at done", busy, 1'b0);
        chk({req, " err"}, err, exp_err);
        cmp_log(req);
        @(negedge clk);
        chk("R11 done one cycle", done, 1'b0);
        repeat (4) @(negedge clk);
        chk("R12 no restart", busy, 1'b0);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 cs in reset", cfg_cs, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 err", err, 1'b0);
        chk("R1 cs", cfg_cs, 1'b0);

        // R5 golden, clean history: restore timer then jump to production
        ecnt = 0; push_pre(); push_read(); push(32'h30022001); push(32'h00003000);
        push_jump(32'h00010000); push_tail();
        run_req(0, 1'b1, 32'h0000_0001, 1'b0, 1'b0, "R5 golden jump");

        // R6 golden, previous record shows internal reprogram
        ecnt = 0; push_pre(); push_read(); push(32'h30022001); push(32'h00003000); push_tail();
        run_req(0, 1'b1, 32'h0005_0001, 1'b0, 1'b0, "R6 stay prev reprog");
        // R6 current record reprogram bit
        run_req(0, 1'b1, 32'h0000_0005, 1'b0, 1'b0, "R6 stay cur reprog");
        // R7 error flags in either record
        run_req(0, 1'b1, 32'h0000_0011, 1'b0, 1'b0, "R7 stay crc");
        run_req(0, 1'b1, 32'h0021_0001, 1'b0, 1'b0, "R7 stay wdt");
        run_req(0, 1'b1, 32'h0000_0009, 1'b0, 1'b0, "R7 stay idcode");
        run_req(0, 1'b1, 32'h0000_0003, 1'b0, 1'b0, "R7 stay fallback");

        // R8 production: read then close
        ecnt = 0; push_pre(); push_read(); push_tail();
        run_req(0, 1'b0, 32'h0000_0001, 1'b0, 1'b0, "R8 production stay");

        // R9 forced direct return
        ecnt = 0; push_pre(); push_jump(32'h00000000); push_tail();
        run_req(1, 1'b0, 32'h0, 1'b0, 1'b0, "R9 forced direct");

        // R10 forced watchdog return
        ecnt = 0; push_pre(); push(32'h30022001); push(32'h40000010);
        push_jump(32'h00010000); push_tail();
        run_req(2, 1'b0, 32'h0, 1'b0, 1'b0, "R10 forced watchdog");

        // R12 requests during busy are ignored
        ecnt = 0; push_pre(); push_read(); push_tail();
        run_req(0, 1'b0, 32'h0000_0001, 1'b1, 1'b0, "R12 ignore while busy");

        // R3 R13 read timeout
        mute = 1'b1;
        ecnt = 0; push_pre(); push_read(); push_tail();
        run_req(0, 1'b1, 32'h0000_0001, 1'b0, 1'b1, "R13 read timeout");
        mute = 1'b0;
        chk("R13 err sticky", err, 1'b1);
        ecnt = 0; push_pre(); push_read(); push_tail();
        run_req(0, 1'b0, 32'h0000_0001, 1'b0, 1'b0, "R13 err cleared R3 read");

        // R4 no written header targets the status register in the last log
        for (int i = 0; i < wcnt; i++)
            if (wlog[i][31:27] == 5'b00110) chk("R4 status never written", {27'd0, wlog[i][17:13]} == 32'h16, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule